// File: doc/BRIEF.md
# Self-Refresh Power-Down Sequencer

This block steps a system's SDRAM into self-refresh before the system clock is gated, and brings it back out afterwards. When sleep is requested, it first asks the arbiter of every bus layer to grant a dummy master. This quiesces all real masters. Once every layer has acknowledged, it requests self-refresh from the memory controller. After the controller acknowledges, it turns off the system clock enable.

On wake, the steps run in reverse. The clock enable comes back first. Then the self-refresh request is withdrawn. Once the controller's acknowledge has fallen, the dummy-master requests are released. Each step waits on its own acknowledge, so the memory never sees traffic while it is in self-refresh, and the clock is never stopped while the controller is active.

A wake event that arrives while entry is still in progress is held, and it takes effect once the gated state is reached. Sleep requests are not honoured until the sequencer has come fully back to rest. The number of bus layers is a parameter.

Top module: `pdsr_sequencer`

## Requirements
- R1: After reset, every quiesce request is 0, the self-refresh request is 0, the clock enable is 1 and busy is 0.
- R2: A sleep request sampled while at rest drives every quiesce request high on the next cycle. The self-refresh request stays low for as long as any layer's acknowledge is low.
- R3: The self-refresh request rises in the cycle after all quiesce acknowledges are sampled high.
- R4: The clock enable falls in the cycle after the self-refresh acknowledge is sampled high while the self-refresh request is high. It stays high before that.
- R5: In the gated state, a wake sample raises the clock enable on the next cycle while the self-refresh request is still high. The self-refresh request falls one cycle later.
- R6: The quiesce requests fall in the cycle after the self-refresh acknowledge is sampled low following withdrawal of the request. They stay high while that acknowledge remains high.
- R7: Busy is high in every state except rest. It falls in the cycle after all quiesce acknowledges are sampled low during release.
- R8: A sleep request sampled while not at rest has no effect. If it is gone by the time the sequencer returns to rest, no new entry starts.
- R9: A wake pulse seen while quiesce or self-refresh entry is in progress is latched. The clock enable is then low for exactly one cycle before it rises again, with no further wake needed.
- R10: A wake pulse seen at rest or during the exit steps is ignored. A later gated state stays gated until a fresh wake arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running sequencer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | Request to power down |
| wake_i | input | 1 | Wake event |
| quiesce_req_o | output | NUM_LAYERS | Per-layer request to grant the dummy master |
| quiesce_ack_i | input | NUM_LAYERS | Per-layer acknowledge that the dummy master holds the bus |
| sr_req_o | output | 1 | Self-refresh request to the memory controller |
| sr_ack_i | input | 1 | Self-refresh acknowledge from the memory controller |
| clk_en_o | output | 1 | System clock enable for the external gate cell |
| busy_o | output | 1 | High whenever the sequencer is not at rest |

## Verification
Every output is registered, so each result appears exactly one clock edge after the input sample that causes it. The one exception is the withdrawal of the self-refresh request, which comes two edges after the wake.

The bench drives each input on a falling edge and advances one rising edge. It then checks on the following falling edge, so each expected value is compared in the first cycle it is due. The hold cases are checked over several cycles: partial acknowledges, a self-refresh acknowledge that is still high, and an ignored wake.

// File: rtl/pdsr_pkg.sv
package pdsr_pkg;

    typedef enum logic [2:0] {
        ST_REST,
        ST_QUIESCE,
        ST_SR_ENTER,
        ST_GATED,
        ST_UNGATE,
        ST_SR_EXIT,
        ST_RELEASE
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       quiesce;
        logic       sr_req;
        logic       clk_en;
    } seq_regs_t;

    localparam seq_regs_t SEQ_RESET = '{
        state:   ST_REST,
        quiesce: 1'b0,
        sr_req:  1'b0,
        clk_en:  1'b1
    };

endpackage

// File: rtl/pdsr_ack_reduce.sv
module pdsr_ack_reduce #(
    parameter int NUM_LAYERS = 3
) (
    input  logic [NUM_LAYERS-1:0] ack_i,
    output logic                  all_set_o,
    output logic                  all_clear_o
);
    logic [NUM_LAYERS:0] and_chain;
    logic [NUM_LAYERS:0] or_chain;

    assign and_chain[0] = 1'b1;
    assign or_chain[0]  = 1'b0;

    for (genvar g = 0; g < NUM_LAYERS; g++) begin : g_layer
        assign and_chain[g+1] = and_chain[g] & ack_i[g];
        assign or_chain[g+1]  = or_chain[g]  | ack_i[g];
    end

    assign all_set_o   = and_chain[NUM_LAYERS];
    assign all_clear_o = ~or_chain[NUM_LAYERS];
endmodule

// File: rtl/pdsr_wake_latch.sv
module pdsr_wake_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic consume_i,
    input  logic wake_i,
    output logic pending_o
);
    logic pend_d, pend_q;

    always_comb begin
        pend_d = pend_q | (arm_i & wake_i);
        if (consume_i) begin
            pend_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pending_o = pend_q;
endmodule

// File: rtl/pdsr_fsm.sv
module pdsr_fsm
    import pdsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_i,
    input  logic wake_i,
    input  logic wake_pend_i,
    input  logic acks_set_i,
    input  logic acks_clear_i,
    input  logic sr_ack_i,
    output logic entry_active_o,
    output logic gated_o,
    output logic quiesce_o,
    output logic sr_req_o,
    output logic clk_en_o,
    output logic busy_o
);
    seq_regs_t regs_d, regs_q;
    logic      wake_go;

    assign wake_go = wake_i | wake_pend_i;

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.state)
            ST_REST: begin
                if (sleep_i) begin
                    regs_d.state   = ST_QUIESCE;
                    regs_d.quiesce = 1'b1;
                end
            end
            ST_QUIESCE: begin
                if (acks_set_i) begin
                    regs_d.state  = ST_SR_ENTER;
                    regs_d.sr_req = 1'b1;
                end
            end
            ST_SR_ENTER: begin
                if (sr_ack_i) begin
                    regs_d.state  = ST_GATED;
                    regs_d.clk_en = 1'b0;
                end
            end
            ST_GATED: begin
                if (wake_go) begin
                    regs_d.state  = ST_UNGATE;
                    regs_d.clk_en = 1'b1;
                end
            end
            ST_UNGATE: begin
                regs_d.state  = ST_SR_EXIT;
                regs_d.sr_req = 1'b0;
            end
            ST_SR_EXIT: begin
                if (!sr_ack_i) begin
                    regs_d.state   = ST_RELEASE;
                    regs_d.quiesce = 1'b0;
                end
            end
            ST_RELEASE: begin
                if (acks_clear_i) begin
                    regs_d.state = ST_REST;
                end
            end
            default: regs_d = SEQ_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= SEQ_RESET;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign entry_active_o = (regs_q.state == ST_QUIESCE) || (regs_q.state == ST_SR_ENTER);
    assign gated_o        = (regs_q.state == ST_GATED);
    assign quiesce_o      = regs_q.quiesce;
    assign sr_req_o       = regs_q.sr_req;
    assign clk_en_o       = regs_q.clk_en;
    assign busy_o         = (regs_q.state != ST_REST);
endmodule

// File: rtl/pdsr_sequencer.sv
module pdsr_sequencer #(
    parameter int NUM_LAYERS = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sleep_req_i,
    input  logic                  wake_i,
    output logic [NUM_LAYERS-1:0] quiesce_req_o,
    input  logic [NUM_LAYERS-1:0] quiesce_ack_i,
    output logic                  sr_req_o,
    input  logic                  sr_ack_i,
    output logic                  clk_en_o,
    output logic                  busy_o
);
    logic acks_set, acks_clear;
    logic entry_active, gated, wake_pend, quiesce;

    pdsr_ack_reduce #(.NUM_LAYERS(NUM_LAYERS)) u_acks (
        .ack_i       (quiesce_ack_i),
        .all_set_o   (acks_set),
        .all_clear_o (acks_clear)
    );

    pdsr_wake_latch u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (entry_active),
        .consume_i (gated),
        .wake_i    (wake_i),
        .pending_o (wake_pend)
    );

    pdsr_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .sleep_i        (sleep_req_i),
        .wake_i         (wake_i),
        .wake_pend_i    (wake_pend),
        .acks_set_i     (acks_set),
        .acks_clear_i   (acks_clear),
        .sr_ack_i       (sr_ack_i),
        .entry_active_o (entry_active),
        .gated_o        (gated),
        .quiesce_o      (quiesce),
        .sr_req_o       (sr_req_o),
        .clk_en_o       (clk_en_o),
        .busy_o         (busy_o)
    );

    assign quiesce_req_o = {NUM_LAYERS{quiesce}};
endmodule

// File: rtl/pdsr_sequencer_chk.sv
module pdsr_sequencer_chk #(
    parameter int NUM_LAYERS = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_LAYERS-1:0] quiesce_req_o,
    input logic [NUM_LAYERS-1:0] quiesce_ack_i,
    input logic                  sr_req_o,
    input logic                  sr_ack_i,
    input logic                  clk_en_o,
    input logic                  busy_o
);
    // R2
    sr_needs_quiesce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_req_o |-> (&quiesce_req_o));

    // R3
    sr_after_all_acks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sr_req_o) |-> $past(&quiesce_ack_i));

    // R4
    gate_after_sr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_en_o) |-> ($past(sr_ack_i) && sr_req_o));

    // R5
    ungate_before_sr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_en_o) |-> sr_req_o);

    // R5
    sr_drop_clock_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sr_req_o) |-> (clk_en_o && $past(clk_en_o)));

    // R6
    release_after_sr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(quiesce_req_o[0]) |-> (!$past(sr_ack_i) && !sr_req_o));

    // R7
    rest_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (clk_en_o && !sr_req_o && (quiesce_req_o == '0)));
endmodule

bind pdsr_sequencer pdsr_sequencer_chk #(.NUM_LAYERS(NUM_LAYERS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .quiesce_req_o (quiesce_req_o),
    .quiesce_ack_i (quiesce_ack_i),
    .sr_req_o      (sr_req_o),
    .sr_ack_i      (sr_ack_i),
    .clk_en_o      (clk_en_o),
    .busy_o        (busy_o)
);

// File: tb/tb_pdsr_sequencer.sv
`timescale 1ns/1ps
module tb_pdsr_sequencer;
    localparam int N = 3;
    localparam logic [N-1:0] ALL = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req_i = 1'b0;
    logic wake_i = 1'b0;
    logic [N-1:0] quiesce_ack_i = '0;
    logic sr_ack_i = 1'b0;
    logic [N-1:0] quiesce_req_o;
    logic sr_req_o, clk_en_o, busy_o;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    pdsr_sequencer #(.NUM_LAYERS(N)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .sleep_req_i   (sleep_req_i),
        .wake_i        (wake_i),
        .quiesce_req_o (quiesce_req_o),
        .quiesce_ack_i (quiesce_ack_i),
        .sr_req_o      (sr_req_o),
        .sr_ack_i      (sr_ack_i),
        .clk_en_o      (clk_en_o),
        .busy_o        (busy_o)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic enter_gated();
        sleep_req_i = 1'b1; step(); sleep_req_i = 1'b0;
        quiesce_ack_i = ALL; step();
        sr_ack_i = 1'b1; step();
    endtask

    task automatic finish_exit();
        while (sr_req_o) step();
        sr_ack_i = 1'b0; step();
        quiesce_ack_i = '0; step();
        chk("R7 back at rest", busy_o, 1'b0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        chk("R1 quiesce reset", quiesce_req_o, '0);
        chk("R1 sr_req reset", sr_req_o, 1'b0);
        chk("R1 clk_en reset", clk_en_o, 1'b1);
        chk("R1 busy reset", busy_o, 1'b0);
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_full_cycle();
        sleep_req_i = 1'b1; step(); sleep_req_i = 1'b0;
        chk("R2 quiesce raised", quiesce_req_o, ALL);
        chk("R7 busy in quiesce", busy_o, 1'b1);
        quiesce_ack_i = 3'b011;
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R2 partial acks hold sr_req", sr_req_o, 1'b0);
        end
        quiesce_ack_i = ALL; step();
        chk("R3 sr_req raised", sr_req_o, 1'b1);
        step();
        chk("R4 clock held before sr_ack", clk_en_o, 1'b1);
        sr_ack_i = 1'b1; step();
        chk("R4 clock gated", clk_en_o, 1'b0);
        sleep_req_i = 1'b1; step(); sleep_req_i = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R4 gated without wake", clk_en_o, 1'b0);
        end
        wake_i = 1'b1; step(); wake_i = 1'b0;
        chk("R5 clock back", clk_en_o, 1'b1);
        chk("R5 sr_req still high", sr_req_o, 1'b1);
        step();
        chk("R5 sr_req dropped", sr_req_o, 1'b0);
        chk("R6 quiesce held", quiesce_req_o, ALL);
        wake_i = 1'b1; step(); wake_i = 1'b0;
        step();
        chk("R6 quiesce held while sr_ack high", quiesce_req_o, ALL);
        sr_ack_i = 1'b0; step();
        chk("R6 quiesce released", quiesce_req_o, '0);
        chk("R7 busy during release", busy_o, 1'b1);
        quiesce_ack_i = 3'b100; step();
        chk("R7 busy while ack pending", busy_o, 1'b1);
        quiesce_ack_i = '0; step();
        chk("R7 rest after acks low", busy_o, 1'b0);
        step(); step();
        chk("R8 stale sleep ignored", busy_o, 1'b0);
        chk("R8 no new quiesce", quiesce_req_o, '0);
    endtask

    task automatic t_wake_at_rest();
        wake_i = 1'b1; step(); wake_i = 1'b0;
        chk("R10 wake at rest ignored", busy_o, 1'b0);
        enter_gated();
        chk("R10 gated reached", clk_en_o, 1'b0);
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R10 no stale wake", clk_en_o, 1'b0);
        end
        wake_i = 1'b1; step(); wake_i = 1'b0;
        chk("R5 wake after rest-time pulse", clk_en_o, 1'b1);
        finish_exit();
    endtask

    task automatic t_early_wake();
        sleep_req_i = 1'b1; step(); sleep_req_i = 1'b0;
        wake_i = 1'b1; step(); wake_i = 1'b0;
        chk("R9 still quiescing", sr_req_o, 1'b0);
        quiesce_ack_i = ALL; step();
        chk("R9 sr_req raised", sr_req_o, 1'b1);
        sr_ack_i = 1'b1; step();
        chk("R9 gated once", clk_en_o, 1'b0);
        step();
        chk("R9 latched wake ungates", clk_en_o, 1'b1);
        chk("R9 sr_req still high", sr_req_o, 1'b1);
        finish_exit();
    endtask

    initial begin
        t_reset();
        t_full_cycle();
        t_wake_at_rest();
        t_early_wake();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule